// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns two asynchronous interrupt pins into interrupt requests for a processor core. Each pin passes through a two-flop synchronizer and a sampling register. The sampled value is then compared with the sample taken one clock earlier. One 8-bit control register, reached through a simple write-strobe and read-data bus, chooses a 2-bit sense mode for each channel. A channel's request reaches the core only while the global enable input and that channel's mask input are both high.

In the edge and change modes a detected event sets a pending flag. The flag stays set until the core acknowledges it. Each flag is a two-state machine. CH_IDLE moves to CH_PENDING on a detected event. CH_PENDING moves back to CH_IDLE on an acknowledge that has no event in the same cycle. In low-level mode the request follows the sampled pin directly and is not stored.

The edge comparison applies the previous cycle's sense mode to the previous sample. Rewriting a channel's sense bits can therefore raise a spurious event. This is intended behaviour, so software should mask the channel while it rewrites those bits.

The same register holds a sleep enable bit and a sleep mode bit. The sleep machine rests in SLP_AWAKE. A sleep strobe that arrives while sleep enable is set moves it for exactly one cycle into SLP_IDLE_REQ or SLP_PDOWN_REQ, and it then returns to SLP_AWAKE.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write stores bits 5:0. The fields are: bit 5 sleep enable, bit 4 sleep mode, bits 3:2 channel-1 sense mode, bits 1:0 channel-0 sense mode. Read data always shows the stored value.
- R2: Writes to bits 7:6 are ignored, and those bits always read as 0.
- R3: With sense mode 00 (low level), a channel's raw request is high exactly while its sampled pin is low. The request drops when the pin returns high and is never latched.
- R4: With sense mode 10 (falling edge), a high-to-low pin change sets the channel's pending flag, and a low-to-high change does not.
- R5: With sense mode 11 (rising edge), a low-to-high pin change sets the pending flag, and a high-to-low change does not.
- R6: With sense mode 01 (any change), a pin change in either direction sets the pending flag.
- R7: A pin change reaches the request output as follows, counting rising clock edges after the change. In level mode the request appears on the 3rd edge. In edge and change modes it appears on the 4th edge and not before. The synchronizer and sampling registers reset to 1.
- R8: irq_req[i] equals the channel's raw request ANDed with irq_gie and irq_mask[i].
- R9: irq_ack[i] clears channel i's pending flag on the next edge. If an event and an acknowledge occur in the same cycle, the flag stays set.
- R10: With the pin steady high, changing a channel's sense mode from 10 to 11 produces a spurious event. With the mask set it appears at the output on the 2nd edge after the write. With the mask cleared the output stays 0, and the flag is still pending afterwards.
- R11: A sleep strobe sampled while sleep enable is 1 gives a one-cycle pulse on the next cycle. The pulse is on sleep_idle_req if sleep mode is 0 and on sleep_pdown_req if sleep mode is 1. With sleep enable 0 there is no pulse. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ext_pin | input | 2 | Asynchronous interrupt pins, bit i is channel i |
| irq_mask | input | 2 | Per-channel interrupt mask |
| irq_gie | input | 1 | Global interrupt enable |
| irq_ack | input | 2 | Per-channel pending acknowledge |
| irq_req | output | 2 | Gated interrupt requests to the core |
| sleep_strobe | input | 1 | Sleep instruction strobe |
| sleep_idle_req | output | 1 | One-cycle idle sleep request |
| sleep_pdown_req | output | 1 | One-cycle power-down request |

## Verification
A pending flag stuck in the wrong state shows on irq_req within one clock. It appears as a request that survives an acknowledge, or as a missing request on the 4th edge after a pin change. A wrong previous-sample or previous-mode register shows as a spurious or missing request 4 edges after a pin change, or 2 edges after a sense-mode write. A faulty sleep machine shows on the sleep outputs in the cycle right after the strobe.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        SLP_AWAKE     = 2'b00,
        SLP_IDLE_REQ  = 2'b01,
        SLP_PDOWN_REQ = 2'b10
    } sleep_state_e;

    // Polarity-adjusted view of a sample: modes that look for a low
    // (level, falling) see the inverted sample, the others see it as is.
    function automatic logic sense_term(input sense_e m, input logic s);
        return (m == SNS_LOW || m == SNS_FALL) ? ~s : s;
    endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [2*NUM_CH-1:0]   modes_o,
    output logic                  sleep_en_o,
    output logic                  sleep_mode_o
);
    localparam int MODE_BITS = 2 * NUM_CH;
    localparam int SM_BIT    = MODE_BITS;
    localparam int SE_BIT    = MODE_BITS + 1;
    localparam int USED      = MODE_BITS + 2;

    logic [USED-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_i) begin
            ctrl_q <= wdata_i[USED-1:0];
        end
    end

    assign rdata_o      = {{(DATA_W-USED){1'b0}}, ctrl_q};
    assign modes_o      = ctrl_q[MODE_BITS-1:0];
    assign sleep_mode_o = ctrl_q[SM_BIT];
    assign sleep_en_o   = ctrl_q[SE_BIT];

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[USED-1:0] == $past(wdata_i[USED-1:0])); // R1

endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    input  logic       ack_i,
    output logic       raw_req_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cur_q;
    logic                   prev_q;
    sense_e                 mode;
    sense_e                 mode_q;
    chan_state_e            state_q;
    chan_state_e            state_d;
    logic                   term_now;
    logic                   term_prev;
    logic                   evt;

    assign mode = sense_e'(mode_i);

    // Synchronizer, sampling register, previous sample and previous mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            cur_q  <= 1'b1;
            prev_q <= 1'b1;
            mode_q <= SNS_LOW;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            cur_q  <= sync_q[SYNC_STAGES-1];
            prev_q <= cur_q;
            mode_q <= mode;
        end
    end

    // Event detection: previous sample judged under the previous mode
    always_comb begin
        term_now  = sense_term(mode, cur_q);
        term_prev = sense_term(mode_q, prev_q);
        unique case (mode)
            SNS_LOW: evt = 1'b0;
            SNS_ANY: evt = term_now ^ term_prev;
            default: evt = term_now & ~term_prev;
        endcase
    end

    // Pending state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Pending next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (evt)            state_d = CH_PENDING;
            CH_PENDING: if (ack_i && !evt)  state_d = CH_IDLE;
            default:                        state_d = CH_IDLE;
        endcase
    end

    // Request output
    always_comb begin
        if (mode == SNS_LOW) raw_req_o = ~cur_q;
        else                 raw_req_o = (state_q == CH_PENDING);
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> state_q == CH_PENDING); // R9

    AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PENDING && ack_i && !evt) |=> state_q == CH_IDLE); // R9

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SNS_LOW && $fell(cur_q)) |-> raw_req_o); // R3

endmodule

// File: rtl/sleep_req_fsm.sv
module sleep_req_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic sleep_en_i,
    input  logic sleep_mode_i,
    output logic idle_req_o,
    output logic pdown_req_o
);
    sleep_state_e state_q;
    sleep_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLP_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = SLP_AWAKE;
        unique case (state_q)
            SLP_AWAKE, SLP_IDLE_REQ, SLP_PDOWN_REQ: begin
                if (strobe_i && sleep_en_i)
                    state_d = sleep_mode_i ? SLP_PDOWN_REQ : SLP_IDLE_REQ;
            end
            default: state_d = SLP_AWAKE;
        endcase
    end

    always_comb begin
        idle_req_o  = 1'b0;
        pdown_req_o = 1'b0;
        unique case (state_q)
            SLP_IDLE_REQ:  idle_req_o  = 1'b1;
            SLP_PDOWN_REQ: pdown_req_o = 1'b1;
            default: ;
        endcase
    end

    AST_SLP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idle_req_o, pdown_req_o})); // R11

    AST_SLP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && sleep_en_i && !sleep_mode_i) |=> idle_req_o); // R11

    AST_SLP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && sleep_en_i) |=> !(idle_req_o || pdown_req_o)); // R11

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl #(
    parameter int DATA_W      = 8,
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] ext_pin,
    input  logic [NUM_CH-1:0] irq_mask,
    input  logic              irq_gie,
    input  logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] irq_req,
    input  logic              sleep_strobe,
    output logic              sleep_idle_req,
    output logic              sleep_pdown_req
);
    logic [2*NUM_CH-1:0] modes;
    logic                sleep_en;
    logic                sleep_mode;
    logic [NUM_CH-1:0]   raw_req;

    irq_ctrl_reg #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (reg_we),
        .wdata_i      (reg_wdata),
        .rdata_o      (reg_rdata),
        .modes_o      (modes),
        .sleep_en_o   (sleep_en),
        .sleep_mode_o (sleep_mode)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (ext_pin[i]),
            .mode_i    (modes[2*i +: 2]),
            .ack_i     (irq_ack[i]),
            .raw_req_o (raw_req[i])
        );

        assign irq_req[i] = raw_req[i] & irq_gie & irq_mask[i];

        AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> (irq_gie && irq_mask[i])); // R8
    end

    sleep_req_fsm u_sleep (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (sleep_strobe),
        .sleep_en_i   (sleep_en),
        .sleep_mode_i (sleep_mode),
        .idle_req_o   (sleep_idle_req),
        .pdown_req_o  (sleep_pdown_req)
    );

endmodule

// File: tb/ext_irq_sense_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_sense_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] ext_pin = 2'b11;
    logic [1:0] irq_mask = 2'b11;
    logic       irq_gie = 1'b1;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq_req;
    logic       sleep_strobe = 1'b0;
    logic       sleep_idle_req;
    logic       sleep_pdown_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ext_irq_sense_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_pin(ext_pin), .irq_mask(irq_mask),
        .irq_gie(irq_gie), .irq_ack(irq_ack), .irq_req(irq_req),
        .sleep_strobe(sleep_strobe), .sleep_idle_req(sleep_idle_req),
        .sleep_pdown_req(sleep_pdown_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic ack_ch(input int ch);
        irq_ack[ch] = 1'b1;
        tick(1);
        irq_ack[ch] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state
        check("R1 reset value", reg_rdata, 8'h00);
        check("R3 no request at reset", {6'b0, irq_req}, 8'h00);
        check("R11 no sleep at reset", {6'b0, sleep_idle_req, sleep_pdown_req}, 8'h00);

        // Register sweep
        irq_gie = 1'b0;
        for (int v = 0; v < 256; v++) begin
            wr(v[7:0]);
            if (v[7:6] != 2'b00) check("R2 reserved bits", reg_rdata, v[7:0] & 8'h3F);
            else                 check("R1 readback", reg_rdata, v[7:0]);
        end
        wr(8'h00);
        irq_gie = 1'b1;

        // Low-level mode per channel
        for (int ch = 0; ch < 2; ch++) begin
            wr(8'h00);
            ext_pin = 2'b11;
            tick(6);
            ext_pin[ch] = 1'b0;
            tick(2);
            check("R7 level latency", {7'b0, irq_req[ch]}, 8'h00);
            tick(1);
            check("R3 level low", {7'b0, irq_req[ch]}, 8'h01);
            tick(4);
            check("R3 level held", {7'b0, irq_req[ch]}, 8'h01);
            ext_pin[ch] = 1'b1;
            tick(3);
            check("R3 level not latched", {7'b0, irq_req[ch]}, 8'h00);
        end

        // Edge-mode sweep: channel x mode x direction
        for (int ch = 0; ch < 2; ch++) begin
            for (int m = 1; m < 4; m++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic expv;
                    ext_pin = 2'b11;
                    ext_pin[ch] = (dir == 1) ? 1'b0 : 1'b1;
                    wr(8'(m << (2 * ch)));
                    tick(6);
                    ack_ch(ch);
                    check("R9 ack clears", {7'b0, irq_req[ch]}, 8'h00);
                    ext_pin[ch] = ~ext_pin[ch];
                    tick(3);
                    check("R7 edge latency", {7'b0, irq_req[ch]}, 8'h00);
                    tick(1);
                    expv = (m == 1) || (m == 2 && dir == 0) || (m == 3 && dir == 1);
                    if (m == 1)      check("R6 any change", {7'b0, irq_req[ch]}, {7'b0, expv});
                    else if (m == 2) check("R4 falling", {7'b0, irq_req[ch]}, {7'b0, expv});
                    else             check("R5 rising", {7'b0, irq_req[ch]}, {7'b0, expv});
                end
            end
        end

        // Gating sweep on channel 0 with a pending flag
        ext_pin = 2'b11;
        wr(8'h01);
        tick(5);
        ack_ch(0);
        ext_pin[0] = 1'b0;
        tick(5);
        for (int g = 0; g < 2; g++) begin
            for (int mk = 0; mk < 2; mk++) begin
                irq_gie = g[0];
                irq_mask[0] = mk[0];
                #1;
                check("R8 gating", {7'b0, irq_req[0]}, {7'b0, g[0] & mk[0]});
            end
        end
        irq_gie = 1'b1;
        irq_mask = 2'b11;
        tick(1);

        // Set wins over acknowledge
        ext_pin[0] = 1'b1;
        tick(3);
        irq_ack[0] = 1'b1;
        tick(1);
        irq_ack[0] = 1'b0;
        check("R9 set wins", {7'b0, irq_req[0]}, 8'h01);
        ack_ch(0);
        check("R9 ack alone", {7'b0, irq_req[0]}, 8'h00);

        // Spurious event on sense change, mask set
        wr(8'h02);
        tick(4);
        ack_ch(0);
        check("R10 clean before change", {7'b0, irq_req[0]}, 8'h00);
        wr(8'h03);
        check("R10 one edge after write", {7'b0, irq_req[0]}, 8'h00);
        tick(1);
        check("R10 false edge with mask", {7'b0, irq_req[0]}, 8'h01);
        // Same change with mask cleared
        irq_mask[0] = 1'b0;
        wr(8'h02);
        tick(3);
        ack_ch(0);
        wr(8'h03);
        tick(3);
        check("R10 suppressed by mask", {7'b0, irq_req[0]}, 8'h00);
        irq_mask[0] = 1'b1;
        #1;
        check("R10 pending behind mask", {7'b0, irq_req[0]}, 8'h01);
        tick(1);
        ack_ch(0);

        // Sleep requests
        for (int se = 0; se < 2; se++) begin
            for (int sm = 0; sm < 2; sm++) begin
                wr(8'((se << 5) | (sm << 4)));
                sleep_strobe = 1'b1;
                tick(1);
                sleep_strobe = 1'b0;
                check("R11 sleep pulse", {6'b0, sleep_idle_req, sleep_pdown_req},
                      {6'b0, 1'(se & ~sm), 1'(se & sm)});
                tick(1);
                check("R11 pulse one cycle", {6'b0, sleep_idle_req, sleep_pdown_req}, 8'h00);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule